// File: doc/BRIEF.md
# Port Input Register with Edge Capture

This block is an 8-bit peripheral input port. A host reads it with a one-cycle read strobe. In the plain mode, the read data shows the live levels of the port pins. When capture is enabled, an active transition on a separate control line freezes the pin values sampled at that moment. The first read after that returns the frozen value. After that read the register becomes transparent again and follows the pins until the next active transition arms it once more.

The active edge of the control line is chosen by one input: rising or falling. Every active edge also raises an interrupt flag, and a port read lowers it. Both the pins and the control line pass through a two-flop synchronizer before use. Edges are found by comparing the current synchronized control sample with the previous one.

The capture logic is a two-state machine:
- `ST_TRANSPARENT` (the reset state) shows the synchronized pins.
- `ST_HELD` shows the stored sample.

Its transitions are:
- CAPTURE: from transparent to held, on an active edge while capture is enabled.
- RECAPTURE: held to held, on a further active edge, which stores a new sample.
- RELEASE_READ: held to transparent, on a read with no edge in the same cycle.
- RELEASE_DISABLE: held to transparent, when capture is switched off.

Top module: `pin_capture_port`

## Requirements
- R1: After reset the port is transparent, `rd_data` is 8'h00 while the pins are low, and `edge_irq` is 0.
- R2: With `latch_en` = 0, `rd_data` equals `port_pins` two clock edges after the pins change, whatever the control line does.
- R3: `edge_rising` = 1 makes a 0-to-1 transition of `ctl_line` active. `edge_rising` = 0 makes a 1-to-0 transition active. A transition in the other direction neither captures nor sets `edge_irq`.
- R4: With `latch_en` = 1, an active edge stores the synchronized pin value present at that edge. `rd_data` then keeps that value while the pins change.
- R5: A read of the held value returns it during the strobe cycle. From the next cycle on, `rd_data` follows the synchronized pins.
- R6: A second active edge before any read replaces the stored value with the newer sample.
- R7: An active edge sets `edge_irq` in the cycle after it is detected. A read with no coincident edge clears it in the following cycle.
- R8: When an active edge and a read fall in the same cycle, `edge_irq` stays 1 and the new sample is held.
- R9: Dropping `latch_en` while a value is held makes `rd_data` follow the pins from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_pins | input | 8 | Asynchronous port pin levels |
| ctl_line | input | 1 | Asynchronous capture control line |
| edge_rising | input | 1 | 1: rising edge active, 0: falling edge active |
| latch_en | input | 1 | Enables capture on the active edge |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_data | output | 8 | Input register contents |
| edge_irq | output | 1 | Active-edge interrupt flag |

## Verification
A machine stuck in `ST_HELD` shows up at the first pin change after a read: `rd_data` stays frozen where it should follow the pins. A machine that never leaves `ST_TRANSPARENT` shows new pin values during the hold window. A stored value that drifts, or an edge detector on the wrong polarity, shows up within four cycles of the control transition. The mismatch appears at `rd_data` or `edge_irq`, sampled against every pin pattern under both edge polarities.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
    localparam int PORT_W = 8;

    typedef enum logic {
        ST_TRANSPARENT = 1'b0,
        ST_HELD        = 1'b1
    } cap_state_t;
endpackage

// File: rtl/pcp_sync.sv
module pcp_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pcp_edge_detect.sv
module pcp_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_s,
    input  logic edge_rising,
    output logic edge_hit
);
    logic ctl_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_prev_q <= 1'b0;
        else        ctl_prev_q <= ctl_s;
    end

    always_comb begin
        if (edge_rising) edge_hit = ctl_s & ~ctl_prev_q;
        else             edge_hit = ~ctl_s & ctl_prev_q;
    end

    // R3: a detected edge must match the selected polarity of the sample
    assert_edge_polarity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |-> (ctl_s == edge_rising));
endmodule

// File: rtl/pcp_capture_fsm.sv
module pcp_capture_fsm
    import pcp_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic         edge_hit,
    input  logic         latch_en,
    input  logic         rd_stb,
    output logic [W-1:0] rd_data,
    output logic         irq
);
    cap_state_t state_q, state_d;
    logic [W-1:0] held_q;
    logic         take_sample;

    always_comb begin
        state_d     = state_q;
        take_sample = 1'b0;
        unique case (state_q)
            ST_TRANSPARENT: begin
                if (latch_en && edge_hit) begin
                    state_d     = ST_HELD;   // CAPTURE
                    take_sample = 1'b1;
                end
            end
            ST_HELD: begin
                if (!latch_en) begin
                    state_d = ST_TRANSPARENT; // RELEASE_DISABLE
                end else if (edge_hit) begin
                    state_d     = ST_HELD;    // RECAPTURE
                    take_sample = 1'b1;
                end else if (rd_stb) begin
                    state_d = ST_TRANSPARENT; // RELEASE_READ
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRANSPARENT;
            held_q  <= '0;
            irq     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_sample) held_q <= pins_s;
            if (edge_hit)    irq <= 1'b1;
            else if (rd_stb) irq <= 1'b0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_TRANSPARENT: rd_data = pins_s;
            ST_HELD:        rd_data = held_q;
        endcase
    end

    assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && edge_hit) |=> (state_q == ST_HELD && held_q == $past(pins_s)));
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !edge_hit) |=> $stable(held_q));
    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && rd_stb && !edge_hit) |=> (state_q == ST_TRANSPARENT));
    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> irq);
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !edge_hit) |=> !irq);
    assert_disable_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> (state_q == ST_TRANSPARENT));
endmodule

// File: rtl/pin_capture_port.sv
module pin_capture_port
    import pcp_pkg::*;
#(
    parameter int W           = PORT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port_pins,
    input  logic         ctl_line,
    input  logic         edge_rising,
    input  logic         latch_en,
    input  logic         rd_stb,
    output logic [W-1:0] rd_data,
    output logic         edge_irq
);
    localparam int SW = W + 1;

    logic [SW-1:0] sync_bus;
    logic [W-1:0]  pins_s;
    logic          ctl_s;
    logic          edge_hit;

    pcp_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ctl_line, port_pins}),
        .sync_out (sync_bus)
    );

    assign pins_s = sync_bus[W-1:0];
    assign ctl_s  = sync_bus[W];

    pcp_edge_detect u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_s       (ctl_s),
        .edge_rising (edge_rising),
        .edge_hit    (edge_hit)
    );

    pcp_capture_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_s   (pins_s),
        .edge_hit (edge_hit),
        .latch_en (latch_en),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data),
        .irq      (edge_irq)
    );

    // R8: coincident edge and read keeps the flag raised
    assert_coincident_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && rd_stb) |=> edge_irq);
endmodule

// File: tb/pin_capture_port_bench.sv
`timescale 1ns/1ps
module pin_capture_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_pins = 8'h00;
    logic       ctl_line = 1'b0;
    logic       edge_rising = 1'b1;
    logic       latch_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       edge_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_capture_port u_pin_capture_port (
        .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .ctl_line(ctl_line),
        .edge_rising(edge_rising), .latch_en(latch_en), .rd_stb(rd_stb),
        .rd_data(rd_data), .edge_irq(edge_irq)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        wait_cyc(1);
        rd_stb = 1'b0;
    endtask

    task automatic settle(input logic idle);
        ctl_line = idle;
        wait_cyc(5);
        do_read();
        wait_cyc(1);
    endtask

    initial begin
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 data", rd_data, 8'h00);
        chk("R1 irq", {7'b0, edge_irq}, 8'h00);

        // R2: transparent path, two-edge delay
        latch_en = 1'b0;
        for (int k = 0; k < 16; k++) begin
            logic [7:0] prev;
            logic [7:0] nv;
            prev = port_pins;
            nv = 8'(k * 37 + 5);
            port_pins = nv;
            wait_cyc(1);
            chk("R2 delay1", rd_data, prev);
            wait_cyc(1);
            chk("R2 delay2", rd_data, nv);
        end
        port_pins = 8'h11;
        ctl_line = 1'b1;
        wait_cyc(4);
        chk("R2 edge ignored", rd_data, 8'h11);
        chk("R7 irq on edge", {7'b0, edge_irq}, 8'h01);
        port_pins = 8'h22;
        wait_cyc(3);
        chk("R2 follows", rd_data, 8'h22);
        ctl_line = 1'b0;
        settle(1'b0);

        // Sweep all pin values under both polarities: R3 R4 R5 R7
        latch_en = 1'b1;
        for (int sel = 0; sel < 2; sel++) begin
            logic idle;
            idle = (sel == 1) ? 1'b0 : 1'b1;
            edge_rising = sel[0];
            settle(idle);
            for (int v = 0; v < 256; v++) begin
                logic [7:0] val;
                val = 8'(v);
                port_pins = val;
                wait_cyc(3);
                ctl_line = ~idle;
                wait_cyc(4);
                chk("R7 irq set", {7'b0, edge_irq}, 8'h01);
                port_pins = ~val;
                wait_cyc(4);
                chk("R4 held", rd_data, val);
                rd_stb = 1'b1;
                chk("R5 read data", rd_data, val);
                wait_cyc(1);
                rd_stb = 1'b0;
                chk("R5 transparent", rd_data, ~val);
                chk("R7 irq clear", {7'b0, edge_irq}, 8'h00);
                ctl_line = idle;
                wait_cyc(4);
                chk("R3 other edge no irq", {7'b0, edge_irq}, 8'h00);
                port_pins = val ^ 8'h5A;
                wait_cyc(3);
                chk("R3 other edge no capture", rd_data, val ^ 8'h5A);
            end
        end

        // R6: overwrite before read
        edge_rising = 1'b1;
        settle(1'b0);
        port_pins = 8'hA5; wait_cyc(3);
        ctl_line = 1'b1; wait_cyc(4);
        ctl_line = 1'b0; wait_cyc(4);
        port_pins = 8'h5C; wait_cyc(3);
        ctl_line = 1'b1; wait_cyc(4);
        port_pins = 8'h00; wait_cyc(3);
        chk("R6 overwrite", rd_data, 8'h5C);
        do_read();
        chk("R6 released", rd_data, 8'h00);

        // R8: edge coincident with read
        ctl_line = 1'b0;
        settle(1'b0);
        port_pins = 8'h3C; wait_cyc(3);
        ctl_line = 1'b1; wait_cyc(4);
        ctl_line = 1'b0; wait_cyc(4);
        port_pins = 8'hC3; wait_cyc(3);
        ctl_line = 1'b1;
        wait_cyc(2);
        rd_stb = 1'b1;
        chk("R8 old held", rd_data, 8'h3C);
        wait_cyc(1);
        rd_stb = 1'b0;
        chk("R8 irq kept", {7'b0, edge_irq}, 8'h01);
        chk("R8 new sample", rd_data, 8'hC3);
        port_pins = 8'h00; wait_cyc(3);
        chk("R8 still held", rd_data, 8'hC3);

        // R9: disable releases hold
        latch_en = 1'b0;
        wait_cyc(1);
        chk("R9 release", rd_data, 8'h00);
        latch_en = 1'b1;
        port_pins = 8'h77; wait_cyc(3);
        chk("R9 stays transparent", rd_data, 8'h77);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule